// File: doc/BRIEF.md
# Bidirectional Bus Reset Repeater

This block joins two bus segments, A and B, that each carry an active-low reset line. A reset asserted on either segment is repeated onto the other segment. The direction is set by whichever side asserts first. While one direction is busy, a reset that shows up on the far side is ignored. Without this lockout the repeated reset would come back as an input and the two drivers could hold each other asserted for ever.

Each repeated pulse is shaped in three ways:
- Once the output asserts, it holds for a programmable number of cycles, even if the input drops away.
- After that, the output tracks the input and releases when the input releases.
- Once released, the output line stays idle for a programmable recovery time before it may be driven again.

Both inputs go through a synchronizer clocked by the block's single clock. All decisions are made on the synchronized values.

Top module: `bus_reset_repeater`

## Requirements
- R1: A synchronous active-high `rst` releases both outputs (logic 1) at the next rising edge. It also clears the input synchronizers, so an input held asserted through reset reaches the opposite output only on the third rising edge after `rst` is sampled low.
- R2: An input assertion (logic 0) that is sampled at rising edge k drives the opposite output low from rising edge k+2. This is two synchronizer stages plus one decision register, so the delay is three edges after the input changes between edges.
- R3: Both directions forward a reset: `a_rst_n_i` low drives `b_rst_n_o` low, and `b_rst_n_i` low drives `a_rst_n_o` low. Each output is released (1) at all other times.
- R4: While one direction is active (in its hold, follow or recovery phase), an assertion of the opposite input is not forwarded. If that input is still asserted once the active direction returns to idle, it is then forwarded.
- R5: Once an output asserts, it stays asserted for at least HOLD_CYC cycles, whatever the input does.
- R6: After the hold interval, the output stays low while the synchronized input stays low. It releases three edges after the input releases, so an input pulse of W cycles gives an output pulse of max(W, HOLD_CYC) cycles.
- R7: After an output releases, it stays released for at least RECOV_CYC cycles. An input seen during that interval is forwarded when the interval ends only if it is still asserted then, which gives a release gap of exactly RECOV_CYC cycles.
- R8: If both directions could start in the same cycle, A-to-B starts and the B-to-A request is not forwarded.
- R9: The two outputs are never asserted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock for synchronizers and control |
| rst | input | 1 | Synchronous active-high module reset |
| a_rst_n_i | input | 1 | Active-low reset received from segment A |
| b_rst_n_i | input | 1 | Active-low reset received from segment B |
| a_rst_n_o | output | 1 | Active-low reset driven onto segment A (repeated from B) |
| b_rst_n_o | output | 1 | Active-low reset driven onto segment B (repeated from A) |

## Verification
The bench builds the block with HOLD_CYC = 4, RECOV_CYC = 3 and two synchronizer stages. With these values, a one-cycle input stretches visibly to four cycles, and a re-assertion lands inside a three-cycle recovery window. A blocked opposite request also clears quickly, so either its forwarding or its loss shows within a few vector rows. Because the hold and recovery lengths differ, an off-by-one or a swapped counter load in either interval changes the observed pulse widths and gaps. The same-cycle tie and a reset in the middle of a pulse are driven directly.

// File: rtl/rrep_pkg.sv
package rrep_pkg;

  // Direction indices; the lower index has priority on a tie
  localparam int DIR_AB  = 0;
  localparam int DIR_BA  = 1;
  localparam int NUM_DIR = 2;

  typedef enum logic [1:0] {
    CH_IDLE   = 2'd0,
    CH_HOLD   = 2'd1,
    CH_FOLLOW = 2'd2,
    CH_RECOV  = 2'd3
  } ch_state_e;

endpackage

// File: rtl/rrep_sync.sv
module rrep_sync #(
  parameter int              WIDTH   = 2,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
    end else begin
      stg_q[0] <= d;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/rrep_channel.sv
module rrep_channel
  import rrep_pkg::*;
#(
  parameter int HOLD_CYC  = 8,
  parameter int RECOV_CYC = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic req,    // synchronized source assertion, active high
  input  logic grant,  // permission to start a new pulse
  output logic want,   // ready to start and source asserted
  output logic idle,
  output logic drive   // registered: drive the destination line
);

  localparam int MAXC = (HOLD_CYC > RECOV_CYC) ? HOLD_CYC : RECOV_CYC;
  localparam int CW   = (MAXC > 1) ? $clog2(MAXC) : 1;
  localparam logic [CW-1:0] HOLD_LD  = CW'(HOLD_CYC - 1);
  localparam logic [CW-1:0] RECOV_LD = CW'(RECOV_CYC - 1);

  ch_state_e      st_q, st_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic           drive_q;
  logic           cnt_zero;

  assign cnt_zero = (cnt_q == '0);
  assign want     = req && ((st_q == CH_IDLE) || ((st_q == CH_RECOV) && cnt_zero));
  assign idle     = (st_q == CH_IDLE);
  assign drive    = drive_q;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    case (st_q)
      CH_IDLE: begin
        if (grant) begin
          st_d  = CH_HOLD;
          cnt_d = HOLD_LD;
        end
      end
      CH_HOLD: begin
        if (!cnt_zero) begin
          cnt_d = cnt_q - 1'b1;
        end else if (req) begin
          st_d = CH_FOLLOW;
        end else begin
          st_d  = CH_RECOV;
          cnt_d = RECOV_LD;
        end
      end
      CH_FOLLOW: begin
        if (!req) begin
          st_d  = CH_RECOV;
          cnt_d = RECOV_LD;
        end
      end
      CH_RECOV: begin
        if (!cnt_zero) begin
          cnt_d = cnt_q - 1'b1;
        end else if (grant) begin
          st_d  = CH_HOLD;
          cnt_d = HOLD_LD;
        end else begin
          st_d = CH_IDLE;
        end
      end
      default: st_d = CH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= CH_IDLE;
      cnt_q   <= '0;
      drive_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      drive_q <= (st_d == CH_HOLD) || (st_d == CH_FOLLOW);
    end
  end

  // ---------------- checking ----------------
  localparam int OW = $clog2(HOLD_CYC + 1);
  localparam int RW = $clog2(RECOV_CYC + 1);
  localparam logic [OW-1:0] ON_SAT  = OW'(HOLD_CYC);
  localparam logic [RW-1:0] OFF_SAT = RW'(RECOV_CYC);

  logic [OW-1:0] on_run_q;
  logic [RW-1:0] off_run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      on_run_q  <= '0;
      off_run_q <= OFF_SAT;
    end else if (drive_q) begin
      on_run_q  <= (on_run_q == ON_SAT) ? on_run_q : on_run_q + 1'b1;
      off_run_q <= '0;
    end else begin
      on_run_q  <= '0;
      off_run_q <= (off_run_q == OFF_SAT) ? off_run_q : off_run_q + 1'b1;
    end
  end

  // R5
  hold_min_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(drive_q) && !$past(rst)) |-> (on_run_q >= ON_SAT));

  // R7
  recov_min_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(drive_q) && !$past(rst)) |-> (off_run_q >= OFF_SAT));

  // R6
  follow_rel_chk: assert property (@(posedge clk) disable iff (rst)
    ((st_q == CH_FOLLOW) && !req) |=> !drive_q);

endmodule

// File: rtl/rrep_lockout.sv
module rrep_lockout
  import rrep_pkg::*;
(
  input  logic [NUM_DIR-1:0] want,
  input  logic [NUM_DIR-1:0] idle,
  output logic [NUM_DIR-1:0] grant
);

  // A direction may start only when the other one is fully idle;
  // A-to-B wins a same-cycle tie.
  always_comb begin
    grant[DIR_AB] = want[DIR_AB] && idle[DIR_BA];
    grant[DIR_BA] = want[DIR_BA] && idle[DIR_AB] && !want[DIR_AB];
  end

endmodule

// File: rtl/bus_reset_repeater.sv
module bus_reset_repeater
  import rrep_pkg::*;
#(
  parameter int HOLD_CYC    = 8,
  parameter int RECOV_CYC   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic a_rst_n_i,
  input  logic b_rst_n_i,
  output logic a_rst_n_o,
  output logic b_rst_n_o
);

  logic [NUM_DIR-1:0] line_n_s;
  logic [NUM_DIR-1:0] req;
  logic [NUM_DIR-1:0] want;
  logic [NUM_DIR-1:0] idle;
  logic [NUM_DIR-1:0] grant;
  logic [NUM_DIR-1:0] drive;

  rrep_sync #(
    .WIDTH  (NUM_DIR),
    .STAGES (SYNC_STAGES),
    .RST_VAL({NUM_DIR{1'b1}})
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({b_rst_n_i, a_rst_n_i}),
    .q   (line_n_s)
  );

  assign req = ~line_n_s;

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    rrep_channel #(
      .HOLD_CYC (HOLD_CYC),
      .RECOV_CYC(RECOV_CYC)
    ) u_ch (
      .clk  (clk),
      .rst  (rst),
      .req  (req[d]),
      .grant(grant[d]),
      .want (want[d]),
      .idle (idle[d]),
      .drive(drive[d])
    );
  end

  rrep_lockout u_lock (
    .want (want),
    .idle (idle),
    .grant(grant)
  );

  assign b_rst_n_o = ~drive[DIR_AB];
  assign a_rst_n_o = ~drive[DIR_BA];

  // R9
  both_drive_chk: assert property (@(posedge clk) disable iff (rst)
    !(!a_rst_n_o && !b_rst_n_o));

  // R4
  lockout_ba_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(drive[DIR_BA]) |-> $past(idle[DIR_AB]));

  // R4
  lockout_ab_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(drive[DIR_AB]) |-> $past(idle[DIR_BA]));

  // R8
  tie_pick_chk: assert property (@(posedge clk) disable iff (rst)
    (want[DIR_AB] && want[DIR_BA]) |=> !drive[DIR_BA]);

  // R1
  reset_release_chk: assert property (@(posedge clk)
    rst |=> (a_rst_n_o && b_rst_n_o));

endmodule

// File: tb/test_bus_reset_repeater.sv
`timescale 1ns/1ps
module test_bus_reset_repeater;

  localparam int HOLD  = 4;
  localparam int RECOV = 3;
  localparam int NSEG  = 26;

  // {rows[7:0], a_in, b_in, exp_a_out, exp_b_out}; checked before inputs apply
  localparam logic [11:0] SEG [NSEG] = '{
    {8'd3, 4'b0111}, {8'd1, 4'b0110}, {8'd2, 4'b0010}, {8'd3, 4'b1010},
    {8'd2, 4'b1011}, {8'd2, 4'b1111}, {8'd4, 4'b1101}, {8'd4, 4'b1111},
    {8'd2, 4'b0111}, {8'd1, 4'b1111}, {8'd2, 4'b1110}, {8'd2, 4'b0110},
    {8'd3, 4'b0111}, {8'd5, 4'b0110}, {8'd3, 4'b1110}, {8'd4, 4'b1111},
    {8'd2, 4'b0011}, {8'd1, 4'b1111}, {8'd2, 4'b1110}, {8'd2, 4'b1010},
    {8'd4, 4'b1111}, {8'd1, 4'b1011}, {8'd2, 4'b1111}, {8'd2, 4'b1101},
    {8'd2, 4'b1001}, {8'd6, 4'b1111}
  };

  logic clk = 1'b0;
  logic rst;
  logic a_in, b_in;
  logic a_out, b_out;
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  always #2.5 clk = ~clk;

  bus_reset_repeater #(
    .HOLD_CYC   (HOLD),
    .RECOV_CYC  (RECOV),
    .SYNC_STAGES(2)
  ) i_bus_reset_repeater (
    .clk      (clk),
    .rst      (rst),
    .a_rst_n_i(a_in),
    .b_rst_n_i(b_in),
    .a_rst_n_o(a_out),
    .b_rst_n_o(b_out)
  );

  function automatic string seg_tag(input int s);
    case (s)
      0, 1:                  return "R2";
      2, 4, 5, 6, 20:        return "R4";
      3, 14, 15:             return "R6";
      7, 10, 11, 24:         return "R5";
      8, 9, 21, 22, 23:      return "R3";
      12, 13, 25:            return "R7";
      default:               return "R8";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [39:0] hist;
    int first_low, last_low, lows, lows_hi, b_lows;

    rst  = 1'b1;
    a_in = 1'b1;
    b_in = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "a_out in reset", a_out, 1);
    chk("R1", "b_out in reset", b_out, 1);
    rst = 1'b0;

    // Vector table walk
    for (int s = 0; s < NSEG; s++) begin
      for (int k = 0; k < int'(SEG[s][11:4]); k++) begin
        chk(seg_tag(s), "a_out", a_out, SEG[s][1]);
        chk(seg_tag(s), "b_out", b_out, SEG[s][0]);
        // R9
        chk("R9", "both outputs low", int'(!a_out && !b_out), 0);
        a_in = SEG[s][3];
        b_in = SEG[s][2];
        @(negedge clk);
      end
    end

    // Directed: latency, then reset in mid-pulse
    a_in = 1'b0;
    @(negedge clk); chk("R2", "b_out one edge after input", b_out, 1);
    @(negedge clk); chk("R2", "b_out two edges after input", b_out, 1);
    @(negedge clk); chk("R2", "b_out three edges after input", b_out, 0);
    rst = 1'b1;
    @(negedge clk);
    chk("R1", "b_out after mid-pulse reset", b_out, 1);
    chk("R1", "a_out after mid-pulse reset", a_out, 1);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk); chk("R1", "b_out one edge after reset", b_out, 1);
    @(negedge clk); chk("R1", "b_out two edges after reset", b_out, 1);
    @(negedge clk); chk("R1", "b_out three edges after reset", b_out, 0);
    a_in = 1'b1;
    repeat (12) @(negedge clk);

    // Directed: B to A long pulse then one-cycle pulse
    b_lows = 0;
    for (int i = 0; i < 40; i++) begin
      hist[i] = a_out;
      if (!b_out) b_lows++;
      b_in = (i < 7 || i == 20) ? 1'b0 : 1'b1;
      @(negedge clk);
    end
    lows = 0; lows_hi = 0; first_low = -1;
    for (int i = 0; i < 40; i++) begin
      if (!hist[i]) begin
        if (i < 20) lows++; else lows_hi++;
        if (first_low < 0) first_low = i;
      end
    end
    chk("R3", "b_out lows during B-to-A traffic", b_lows, 0);
    chk("R2", "B-to-A first low row", first_low, 3);
    chk("R6", "a_out width for 7-cycle input", lows, 7);
    chk("R5", "a_out width for 1-cycle input", lows_hi, HOLD);

    // Directed: re-assert just after release, measure the gap
    for (int i = 0; i < 40; i++) begin
      hist[i] = b_out;
      a_in = (i < 6 || (i >= 7 && i < 13)) ? 1'b0 : 1'b1;
      @(negedge clk);
    end
    lows = 0; first_low = -1; last_low = -1;
    for (int i = 0; i < 40; i++) begin
      if (!hist[i]) begin
        lows++;
        if (first_low < 0) first_low = i;
        last_low = i;
      end
    end
    chk("R7", "release gap", (last_low - first_low + 1) - lows, RECOV);
    chk("R6", "total low rows of both pulses", lows, 10);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule